// File: doc/BRIEF.md
# PHY Management Register File

This block is the register bank a station manager sees when it talks to an Ethernet PHY over the management channel. It is fed by a plain synchronous access port with a 5-bit register number, 16-bit write data, and read and write strobes. It holds the control, status, advertisement, interrupt-source and interrupt-mask registers. The identifier, link-partner ability and expansion registers return fixed values. The serial framing of the management bus and the real negotiation with a link partner sit outside this block. Negotiation is modelled as finishing the moment it is enabled.

A link-status input is synchronised and watched for edges. Each transition updates the link and negotiation-done bits in status and posts its own interrupt causes. The source register clears when read. A single level interrupt output is high while any posted cause is also enabled in the mask. Both a hardware reset and a software reset through the control register restore every register. The current link level is then applied again once the synchroniser has refilled.

Top module: `phy_mgmt_regfile`

## Requirements
- R1: After reset, control (reg 0) reads 0x3000, status (reg 1) reads 0x7809, advertisement (reg 4) reads 0x01E1, and mask (reg 30) and source (reg 29) read 0, before the link level is applied.
- R2: A control write with bit 15 clear stores only bits 14, 13, 12, 11, 8 and 7 (mask 0x7980), and every other control bit reads back 0.
- R3: A control write with bit 15 set restores all registers to their R1 values and applies none of its other bits. The cycle after it carries no link event.
- R4: A control write with bit 15 clear and bit 12 set sets status bit 5 (negotiation done).
- R5: An advertisement write keeps only bits 13, 11, 10, 8, 6, 5 and 4:0 (mask 0x2D7F), and bit 7 always reads 1.
- R6: The mask register stores write bits 7:0 and reads 0 in bits 15:8. `irq` is high exactly when source AND mask is non-zero.
- R7: A strobed read of reg 29 returns the source value and clears it at that clock edge. A cause posted at the same edge stays set.
- R8: A link drop clears status bits 2 and 5 and sets source bit 4. A link rise sets status bits 2 and 5 and source bits 7 and 6. The effect is visible after the third rising edge that follows the input change, with SYNC_STAGES=2.
- R9: After a hardware or software reset, the synchronised link level is applied as a rise or drop event SYNC_STAGES+1 edges later.
- R10: Reg 2 reads PHY_ID_HI (default 0x2A5C), reg 3 reads PHY_ID_LO (default 0x71F3), reg 5 reads 0x0FE1, and reg 6 reads 0x0001.
- R11: Regs 17, 18, 27, 31 and all other unmapped numbers read 0. Writes to them, and to the read-only regs 1, 2, 3, 5, 6 and 29, change nothing.
- R12: `rdData` is 0 while `rdStb` is low, and presenting reg 29 without `rdStb` does not clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 5 | Register number for the access |
| wrData | input | 16 | Write data |
| wrStb | input | 1 | Write strobe, one cycle per write |
| rdStb | input | 1 | Read strobe, one cycle per read |
| rdData | output | 16 | Read data, valid in the strobe cycle |
| linkUp | input | 1 | Asynchronous link level, 1 = up |
| irq | output | 1 | Level interrupt |

## Verification
Read data is combinational and is due in the same cycle as the strobe. The bench drives at the falling edge and samples 2 ns later, before the next rising edge. Register writes, clear-on-read and soft resets take effect at the rising edge that ends the access, so the bench checks them with a read on a later cycle. A link change is due after the third rising edge. The bench confirms that the old value still holds after the second edge and that the new value appears after the third. Reset re-application lands SYNC_STAGES+1 edges after reset, and the bench reads the source register only after that point, or deliberately before it to see zero.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;
  localparam int INT_W  = 8;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 5'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT  = 5'd1;
  localparam logic [ADDR_W-1:0] ADDR_ID1   = 5'd2;
  localparam logic [ADDR_W-1:0] ADDR_ID2   = 5'd3;
  localparam logic [ADDR_W-1:0] ADDR_ADV   = 5'd4;
  localparam logic [ADDR_W-1:0] ADDR_LPA   = 5'd5;
  localparam logic [ADDR_W-1:0] ADDR_EXP   = 5'd6;
  localparam logic [ADDR_W-1:0] ADDR_ISRC  = 5'd29;
  localparam logic [ADDR_W-1:0] ADDR_IMASK = 5'd30;

  localparam int CTRL_RESET_BIT = 15;
  localparam int CTRL_ANEN_BIT  = 12;
  localparam logic [DATA_W-1:0] CTRL_WR_MASK = 16'h7980;
  localparam logic [DATA_W-1:0] CTRL_RST_VAL = 16'h3000;

  localparam int STAT_ANDONE_BIT = 5;
  localparam int STAT_LINK_BIT   = 2;
  localparam logic [DATA_W-1:0] STAT_RST_VAL = 16'h7809;

  localparam logic [DATA_W-1:0] ADV_WR_MASK = 16'h2D7F;
  localparam logic [DATA_W-1:0] ADV_FORCED  = 16'h0080;
  localparam logic [DATA_W-1:0] ADV_RST_VAL = 16'h01E1;

  localparam logic [DATA_W-1:0] LPA_VAL = 16'h0FE1;
  localparam logic [DATA_W-1:0] EXP_VAL = 16'h0001;

  localparam int INT_ENERGY_BIT   = 7;
  localparam int INT_ANDONE_BIT   = 6;
  localparam int INT_LINKDOWN_BIT = 4;

  typedef struct packed {
    logic wrCtrl;
    logic ctrlAnEn;
    logic softReset;
    logic wrAdv;
    logic wrMask;
    logic rdClrSrc;
    logic linkUpEvt;
    logic linkDownEvt;
  } mgmtStrobes_t;

endpackage

// File: rtl/phy_mgmt_linksync.sv
module phy_mgmt_linksync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic linkAsync,
  output logic linkSynced
);

  logic [STAGES-1:0] chain;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[0] <= 1'b0;
        else       chain[0] <= linkAsync;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[g] <= 1'b0;
        else       chain[g] <= chain[g-1];
      end
    end
  end

  assign linkSynced = chain[STAGES-1];

endmodule

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
  import phy_mgmt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrStb,
  input  logic              rdStb,
  input  logic              wrRstBit,
  input  logic              wrAnEnBit,
  input  logic              linkSynced,
  output mgmtStrobes_t      stb
);

  localparam int CNT_W = $clog2(SYNC_STAGES + 1);

  logic             pending;
  logic [CNT_W-1:0] waitCnt;
  logic             linkPrev;
  logic             softReset;
  logic             applyNow;
  logic             edgeLive;

  assign softReset = wrStb && (regAddr == ADDR_CTRL) && wrRstBit;
  assign applyNow  = pending && (waitCnt == '0) && !softReset;
  assign edgeLive  = !pending && !softReset;

  always_comb begin
    stb             = '0;
    stb.softReset   = softReset;
    stb.wrCtrl      = wrStb && (regAddr == ADDR_CTRL) && !wrRstBit;
    stb.ctrlAnEn    = stb.wrCtrl && wrAnEnBit;
    stb.wrAdv       = wrStb && (regAddr == ADDR_ADV);
    stb.wrMask      = wrStb && (regAddr == ADDR_IMASK);
    stb.rdClrSrc    = rdStb && (regAddr == ADDR_ISRC);
    stb.linkUpEvt   = (applyNow && linkSynced) ||
                      (edgeLive && linkSynced && !linkPrev);
    stb.linkDownEvt = (applyNow && !linkSynced) ||
                      (edgeLive && !linkSynced && linkPrev);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending  <= 1'b1;
      waitCnt  <= CNT_W'(SYNC_STAGES);
      linkPrev <= 1'b0;
    end else if (softReset) begin
      pending  <= 1'b1;
      waitCnt  <= CNT_W'(SYNC_STAGES);
    end else if (pending) begin
      if (waitCnt == '0) begin
        pending  <= 1'b0;
        linkPrev <= linkSynced;
      end else begin
        waitCnt <= waitCnt - 1'b1;
      end
    end else begin
      linkPrev <= linkSynced;
    end
  end

  // R8
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.linkUpEvt, stb.linkDownEvt}));

  // R3
  quiet_after_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.softReset |=> !stb.linkUpEvt && !stb.linkDownEvt);

endmodule

// File: rtl/phy_mgmt_datapath.sv
module phy_mgmt_datapath
  import phy_mgmt_pkg::*;
#(
  parameter logic [DATA_W-1:0] PHY_ID_HI = 16'h2A5C,
  parameter logic [DATA_W-1:0] PHY_ID_LO = 16'h71F3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              rdStb,
  input  logic [DATA_W-1:0] wrData,
  input  mgmtStrobes_t      stb,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);

  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] statReg;
  logic [DATA_W-1:0] advReg;
  logic [INT_W-1:0]  intSrc;
  logic [INT_W-1:0]  intMask;

  logic [DATA_W-1:0] statNext;
  logic [INT_W-1:0]  srcSet;
  logic [INT_W-1:0]  srcNext;
  logic [DATA_W-1:0] muxVal;

  always_comb begin
    statNext = statReg;
    srcSet   = '0;
    if (stb.ctrlAnEn) statNext[STAT_ANDONE_BIT] = 1'b1;
    if (stb.linkDownEvt) begin
      statNext[STAT_ANDONE_BIT]  = 1'b0;
      statNext[STAT_LINK_BIT]    = 1'b0;
      srcSet[INT_LINKDOWN_BIT]   = 1'b1;
    end
    if (stb.linkUpEvt) begin
      statNext[STAT_ANDONE_BIT]  = 1'b1;
      statNext[STAT_LINK_BIT]    = 1'b1;
      srcSet[INT_ENERGY_BIT]     = 1'b1;
      srcSet[INT_ANDONE_BIT]     = 1'b1;
    end
    srcNext = (stb.rdClrSrc ? '0 : intSrc) | srcSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= CTRL_RST_VAL;
      statReg <= STAT_RST_VAL;
      advReg  <= ADV_RST_VAL;
      intSrc  <= '0;
      intMask <= '0;
    end else if (stb.softReset) begin
      ctrlReg <= CTRL_RST_VAL;
      statReg <= STAT_RST_VAL;
      advReg  <= ADV_RST_VAL;
      intSrc  <= '0;
      intMask <= '0;
    end else begin
      if (stb.wrCtrl) ctrlReg <= wrData & CTRL_WR_MASK;
      if (stb.wrAdv)  advReg  <= (wrData & ADV_WR_MASK) | ADV_FORCED;
      if (stb.wrMask) intMask <= wrData[INT_W-1:0];
      statReg <= statNext;
      intSrc  <= srcNext;
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_CTRL:  muxVal = ctrlReg;
      ADDR_STAT:  muxVal = statReg;
      ADDR_ID1:   muxVal = PHY_ID_HI;
      ADDR_ID2:   muxVal = PHY_ID_LO;
      ADDR_ADV:   muxVal = advReg;
      ADDR_LPA:   muxVal = LPA_VAL;
      ADDR_EXP:   muxVal = EXP_VAL;
      ADDR_ISRC:  muxVal = {{(DATA_W-INT_W){1'b0}}, intSrc};
      ADDR_IMASK: muxVal = {{(DATA_W-INT_W){1'b0}}, intMask};
      default:    muxVal = '0;
    endcase
  end

  assign rdData = rdStb ? muxVal : '0;
  assign irq    = |(intSrc & intMask);

  // R7
  src_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdClrSrc && !stb.linkUpEvt && !stb.linkDownEvt) |=> intSrc == '0);

  // R4
  an_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ctrlAnEn && !stb.linkDownEvt) |=> statReg[STAT_ANDONE_BIT]);

  // R3
  soft_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.softReset |=> (ctrlReg == CTRL_RST_VAL) && (advReg == ADV_RST_VAL) &&
                      (intMask == '0) && (intSrc == '0));

  // R8
  link_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.linkDownEvt |=> !statReg[STAT_LINK_BIT] && !statReg[STAT_ANDONE_BIT] &&
                        intSrc[INT_LINKDOWN_BIT]);

  // R8
  link_up_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.linkUpEvt |=> statReg[STAT_LINK_BIT] && statReg[STAT_ANDONE_BIT] &&
                      intSrc[INT_ENERGY_BIT] && intSrc[INT_ANDONE_BIT]);

  // R6
  mask_hi_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && regAddr == ADDR_IMASK) |-> rdData[DATA_W-1:INT_W] == '0);

endmodule

// File: rtl/phy_mgmt_regfile.sv
module phy_mgmt_regfile
  import phy_mgmt_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] PHY_ID_HI   = 16'h2A5C,
  parameter logic [DATA_W-1:0] PHY_ID_LO   = 16'h71F3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrStb,
  input  logic              rdStb,
  output logic [DATA_W-1:0] rdData,
  input  logic              linkUp,
  output logic              irq
);

  logic         linkSynced;
  mgmtStrobes_t stb;

  phy_mgmt_linksync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk        (clk),
    .rstN       (rstN),
    .linkAsync  (linkUp),
    .linkSynced (linkSynced)
  );

  phy_mgmt_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .regAddr    (regAddr),
    .wrStb      (wrStb),
    .rdStb      (rdStb),
    .wrRstBit   (wrData[CTRL_RESET_BIT]),
    .wrAnEnBit  (wrData[CTRL_ANEN_BIT]),
    .linkSynced (linkSynced),
    .stb        (stb)
  );

  phy_mgmt_datapath #(.PHY_ID_HI(PHY_ID_HI), .PHY_ID_LO(PHY_ID_LO)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .regAddr (regAddr),
    .rdStb   (rdStb),
    .wrData  (wrData),
    .stb     (stb),
    .rdData  (rdData),
    .irq     (irq)
  );

endmodule

// File: tb/phy_mgmt_regfile_tb_top.sv
module phy_mgmt_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [15:0] wrData = '0;
  logic        wrStb = 1'b0;
  logic        rdStb = 1'b0;
  logic [15:0] rdData;
  logic        linkUp = 1'b0;
  logic        irq;

  int checks = 0;
  int failures = 0;

  phy_mgmt_regfile dut_i (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrData(wrData),
    .wrStb(wrStb), .rdStb(rdStb), .rdData(rdData), .linkUp(linkUp), .irq(irq)
  );

  always #10 clk = ~clk;

  // vector: {isWrite, addr[4:0], data[15:0], expect[15:0], req[7:0]}
  localparam int NV = 22;
  localparam logic [45:0] VECS [NV] = '{
    {1'b0, 5'd29, 16'h0000, 16'h0010, 8'd9},   // R9 link-down applied after reset
    {1'b0, 5'd29, 16'h0000, 16'h0000, 8'd7},   // R7 cleared by previous read
    {1'b0, 5'd0,  16'h0000, 16'h3000, 8'd1},   // R1
    {1'b0, 5'd1,  16'h0000, 16'h7809, 8'd1},   // R1
    {1'b0, 5'd4,  16'h0000, 16'h01E1, 8'd1},   // R1
    {1'b0, 5'd30, 16'h0000, 16'h0000, 8'd1},   // R1
    {1'b1, 5'd0,  16'h7FFF, 16'h0000, 8'd2},   // R2 write
    {1'b0, 5'd0,  16'h0000, 16'h7980, 8'd2},   // R2
    {1'b0, 5'd1,  16'h0000, 16'h7829, 8'd4},   // R4
    {1'b1, 5'd0,  16'h0000, 16'h0000, 8'd2},   // R2 write
    {1'b0, 5'd0,  16'h0000, 16'h0000, 8'd2},   // R2
    {1'b1, 5'd4,  16'hFFFF, 16'h0000, 8'd5},   // R5 write
    {1'b0, 5'd4,  16'h0000, 16'h2DFF, 8'd5},   // R5
    {1'b1, 5'd4,  16'h0000, 16'h0000, 8'd5},   // R5 write
    {1'b0, 5'd4,  16'h0000, 16'h0080, 8'd5},   // R5 forced bit
    {1'b1, 5'd30, 16'hFFFF, 16'h0000, 8'd6},   // R6 write
    {1'b0, 5'd30, 16'h0000, 16'h00FF, 8'd6},   // R6
    {1'b0, 5'd2,  16'h0000, 16'h2A5C, 8'd10},  // R10
    {1'b0, 5'd3,  16'h0000, 16'h71F3, 8'd10},  // R10
    {1'b0, 5'd5,  16'h0000, 16'h0FE1, 8'd10},  // R10
    {1'b0, 5'd6,  16'h0000, 16'h0001, 8'd10},  // R10
    {1'b1, 5'd17, 16'hFFFF, 16'h0000, 8'd11}   // R11 write
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doWrite(input logic [4:0] a, input logic [15:0] d);
    regAddr = a; wrData = d; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0; wrData = '0;
  endtask

  task automatic doRead(input logic [4:0] a, output logic [15:0] d);
    regAddr = a; rdStb = 1'b1;
    #2 d = rdData;
    @(negedge clk);
    rdStb = 1'b0;
  endtask

  task automatic readCheck(input logic [4:0] a, input logic [15:0] exp,
                           input string req);
    logic [15:0] v;
    doRead(a, v);
    check(v == exp, req, $sformatf("reg%0d", a), v, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (6) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i][45]) begin
        doWrite(VECS[i][44:40], VECS[i][39:24]);
      end else begin
        readCheck(VECS[i][44:40], VECS[i][23:8], $sformatf("R%0d", VECS[i][7:0]));
      end
    end
    readCheck(5'd17, 16'h0000, "R11");
    readCheck(5'd31, 16'h0000, "R11");
    readCheck(5'd12, 16'h0000, "R11");
    doWrite(5'd1, 16'h0000);
    doWrite(5'd29, 16'hFFFF);
    readCheck(5'd1, 16'h7829, "R11");
    readCheck(5'd29, 16'h0000, "R11");

    // R6 idle irq low with empty source
    #2 check(irq == 1'b0, "R6", "irq idle", {15'd0, irq}, 16'h0000);

    // R8 link rise timing: old after 2 edges, new after 3
    linkUp = 1'b1;
    repeat (2) @(negedge clk);
    doRead(5'd1, v);
    check(v[2] == 1'b0, "R8", "link bit after 2 edges", v, 16'h7829);
    readCheck(5'd1, 16'h782D, "R8");
    #2 check(irq == 1'b1, "R6", "irq with cause", {15'd0, irq}, 16'h0001);
    readCheck(5'd29, 16'h00C0, "R8");
    #2 check(irq == 1'b0, "R7", "irq after clear", {15'd0, irq}, 16'h0000);

    // R12 no strobe: zero data, no clear
    linkUp = 1'b0;
    repeat (4) @(negedge clk);
    regAddr = 5'd29;
    #2 check(rdData == 16'h0000, "R12", "rdData no strobe", rdData, 16'h0000);
    repeat (2) @(negedge clk);
    readCheck(5'd29, 16'h0010, "R12");
    readCheck(5'd1, 16'h7809, "R8");

    // R7 set and clear in the same edge
    linkUp = 1'b1;
    repeat (2) @(negedge clk);
    readCheck(5'd29, 16'h0000, "R7");
    readCheck(5'd29, 16'h00C0, "R7");

    // R3 soft reset ignores other fields
    doWrite(5'd0, 16'h9FFF);
    readCheck(5'd29, 16'h0000, "R3");
    readCheck(5'd0, 16'h3000, "R3");
    readCheck(5'd30, 16'h0000, "R3");
    readCheck(5'd4, 16'h01E1, "R3");
    repeat (2) @(negedge clk);
    readCheck(5'd29, 16'h00C0, "R9");
    readCheck(5'd1, 16'h782D, "R9");

    // R1/R9 hardware reset with link up
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    readCheck(5'd1, 16'h7809, "R1");
    readCheck(5'd29, 16'h0000, "R1");
    repeat (4) @(negedge clk);
    readCheck(5'd29, 16'h00C0, "R9");

    // R6 mask selects causes
    doWrite(5'd30, 16'h0010);
    linkUp = 1'b0;
    repeat (4) @(negedge clk);
    #2 check(irq == 1'b1, "R6", "irq masked-in cause", {15'd0, irq}, 16'h0001);
    @(negedge clk);
    doWrite(5'd30, 16'h0040);
    #2 check(irq == 1'b0, "R6", "irq masked-out cause", {15'd0, irq}, 16'h0000);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule